// File: doc/BRIEF.md
# Johnson-Counter Stepped Sine Synthesizer

The block is a small digital sine source. A twisted-ring shift register steps through 2N legal states at the clock rate. Each state is turned into one signed sample of a cosine by a fixed weighted sum. In that sum every register bit counts as +1 when high and −1 when low. The weights are paired: bit k and bit N−1−k carry the same weight, give or take one LSB. They are stored as 16-bit unsigned fractions whose total is 65535, so the sample word never leaves the 17-bit two's-complement range.

The sum is computed at several tap offsets, which gives extra phases. For an even register length there is a quadrature word, taken N/2 states behind the main one. For lengths divisible by three (6 and 12) there are two more words, 2N/3 and 4N/3 states behind, which together with the main word form a three-phase set. A clock enable sets the output rate. A register pattern that is not a single run of ones or zeros starting at bit 0 is thrown away on the next enabled clock, so the counter cannot stay in a parasitic cycle. Downstream, the samples drive a converter and a reconstruction filter, both outside this block.

Top module: `jss_synth`

## Requirements
- R1: While `rst` is high at a clock edge, `ring_q` becomes all zeros and all four sample words become 0.
- R2: On an enabled edge from a legal pattern, bit k+1 takes the old bit k, and bit 0 takes the inverse of the old bit N−1.
- R3: Starting from all zeros, the legal pattern sequence repeats after exactly 2N enabled edges, so the sample period is 2N enabled clocks (12 for N=6).
- R4: A bit at 1 adds its weight and a bit at 0 subtracts it. The all-zeros pattern yields exactly −65535 and the all-ones pattern yields exactly +65535.
- R5: The state reached after s enabled edges from reset yields −cos(s·180°/N)·65535, within ±1 LSB. `sample_i` shows this value one enabled edge after that state appears on `ring_q`.
- R6: For even N, `sample_q` is the sum for the state N/2 steps earlier, which is −sin(s·180°/N) within ±1 LSB, with the same one-edge latency.
- R7: For N divisible by three, `sample_b` and `sample_c` are the sums for the states 2N/3 and 4N/3 steps earlier, within ±1 LSB (lags of 4 and 8 states for N=6).
- R8: A pattern with more than one bit-to-bit change along `ring_q` is replaced by all zeros on the next enabled edge. Counting resumes from there on the edge after.
- R9: An edge with `en` low changes no output: `ring_q` and all sample words hold.
- R10: Weights are 16-bit unsigned fractions summing to 65535. Every sample word is 17-bit two's complement in the range −65535 to +65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the counter and the sample registers |
| ring_q | output | N | Raw twisted-ring register bits, bit 0 first in the shift |
| sample_i | output | W+1 | Main cosine sample, signed |
| sample_q | output | W+1 | Quadrature sample, signed (0 for odd N) |
| sample_b | output | W+1 | Second phase of a three-phase set, signed (0 unless N divisible by 3) |
| sample_c | output | W+1 | Third phase of a three-phase set, signed (0 unless N divisible by 3) |

## Verification
The assertions assume that the register can only become illegal while reset is held, so that no legal-to-illegal jump happens between two enabled, non-reset edges. The bench meets this by injecting each illegal pattern only in the gap after a reset cycle. The full-scale assertions assume the default weight set for N=6, with W=16. The stimulus keeps the default parameters and mixes enabled runs with enable-low gaps of different lengths, so that hold and advance both occur from many different states.

// File: rtl/jss_pkg.sv
package jss_pkg;

  // Conductance of bit k for a register of length n, scaled so that the
  // n weights sum to 2**w - 1. The pairs differ by at most one LSB.
  function automatic int jss_weight(int n, int k, int w);
    int base;
    base = 0;
    if (n == 6) begin
      case (k)
        0, 5:    base = 4390;
        1, 4:    base = 11994;
        2:       base = 16384;
        default: base = 16383;
      endcase
    end else if (n == 12) begin
      case (k)
        0, 11:   base = 1117;
        1, 10:   base = 3273;
        2, 9:    base = 5207;
        3, 8:    base = 6786;
        4, 7:    base = 7903;
        5:       base = 8481;
        default: base = 8482;
      endcase
    end
    return base >> (16 - w);
  endfunction

endpackage

// File: rtl/jss_ring.sv
module jss_ring #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] q
);
  localparam int EW = N - 1;

  logic [N-1:0]  q_r;
  logic [EW-1:0] edges;
  logic          legal;

  // A legal pattern is one run from bit 0 followed by the opposite run.
  assign edges = q_r[N-1:1] ^ q_r[N-2:0];
  assign legal = ($countones(edges) <= 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (en) begin
      if (!legal) q_r <= '0;
      else        q_r <= {q_r[N-2:0], ~q_r[N-1]};
    end
  end

  assign q = q_r;
endmodule

// File: rtl/jss_tap.sv
module jss_tap #(
  parameter int N   = 6,
  parameter int LAG = 0
) (
  input  logic [N-1:0] q,
  output logic [N-1:0] lagged
);
  // The pattern LAG states earlier: a rotation of the ring with the
  // wrapped-around bits inverted.
  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int M = (k + LAG) % (2 * N);
    if (M < N) begin : g_direct
      assign lagged[k] = q[M];
    end else begin : g_invert
      assign lagged[k] = ~q[M - N];
    end
  end
endmodule

// File: rtl/jss_sum.sv
module jss_sum #(
  parameter int N = 6,
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [N-1:0]       bits,
  output logic signed [W:0]  sample
);
  import jss_pkg::*;
  localparam int AW = W + 2;

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] term;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int k = 0; k < N; k++) begin
      term = AW'(jss_weight(N, k, W));
      acc  = bits[k] ? acc + term : acc - term;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sample <= '0;
    else if (en) sample <= acc[W:0];
  end
endmodule

// File: rtl/jss_synth.sv
module jss_synth #(
  parameter int N = 6,
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [N-1:0]      ring_q,
  output logic signed [W:0] sample_i,
  output logic signed [W:0] sample_q,
  output logic signed [W:0] sample_b,
  output logic signed [W:0] sample_c
);
  localparam bit HAS_QUAD  = (N % 2) == 0;
  localparam bit HAS_THREE = (N % 3) == 0;

  logic [N-1:0] state;

  jss_ring #(.N(N)) u_ring (
    .clk (clk), .rst (rst), .en (en), .q (state)
  );

  assign ring_q = state;

  jss_sum #(.N(N), .W(W)) u_sum_i (
    .clk (clk), .rst (rst), .en (en), .bits (state), .sample (sample_i)
  );

  if (HAS_QUAD) begin : g_quad
    logic [N-1:0] bits_q;
    jss_tap #(.N(N), .LAG(N / 2)) u_tap (.q (state), .lagged (bits_q));
    jss_sum #(.N(N), .W(W)) u_sum (
      .clk (clk), .rst (rst), .en (en), .bits (bits_q), .sample (sample_q)
    );
  end else begin : g_no_quad
    assign sample_q = '0;
  end

  if (HAS_THREE) begin : g_three
    logic [N-1:0] bits_b;
    logic [N-1:0] bits_c;
    jss_tap #(.N(N), .LAG(2 * N / 3)) u_tap_b (.q (state), .lagged (bits_b));
    jss_tap #(.N(N), .LAG(4 * N / 3)) u_tap_c (.q (state), .lagged (bits_c));
    jss_sum #(.N(N), .W(W)) u_sum_b (
      .clk (clk), .rst (rst), .en (en), .bits (bits_b), .sample (sample_b)
    );
    jss_sum #(.N(N), .W(W)) u_sum_c (
      .clk (clk), .rst (rst), .en (en), .bits (bits_c), .sample (sample_c)
    );
  end else begin : g_no_three
    assign sample_b = '0;
    assign sample_c = '0;
  end
endmodule

// File: rtl/jss_synth_chk.sv
module jss_synth_chk #(
  parameter int N = 6,
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [N-1:0]      ring_q,
  input logic signed [W:0] sample_i,
  input logic signed [W:0] sample_q,
  input logic signed [W:0] sample_b,
  input logic signed [W:0] sample_c
);
  localparam int FULL = (2 ** W) - 1;

  logic lg;
  assign lg = ($countones(ring_q[N-1:1] ^ ring_q[N-2:0]) <= 1);

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (en && lg) |=> (ring_q == {$past(ring_q[N-2:0]), ~$past(ring_q[N-1])}));

  assert_full_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (en && ring_q == '0) |=> (sample_i == -FULL));

  assert_full_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (en && (&ring_q)) |=> (sample_i == FULL));

  assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !lg) |=> (ring_q == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ring_q) && $stable(sample_i) && $stable(sample_q)
             && $stable(sample_b) && $stable(sample_c)));
endmodule

bind jss_synth jss_synth_chk #(.N(N), .W(W)) u_chk (
  .clk (clk), .rst (rst), .en (en), .ring_q (ring_q),
  .sample_i (sample_i), .sample_q (sample_q),
  .sample_b (sample_b), .sample_c (sample_c)
);

// File: tb/jss_synth_bench.sv
module jss_synth_bench;
  localparam int  N     = 6;
  localparam int  W     = 16;
  localparam int  FULL  = (2 ** W) - 1;
  localparam int  CLK_P = 10;
  localparam real PI    = 3.14159265358979;

  typedef struct {
    int           kind;   // 0 run, 1 reset, 2 hold, 3 recovery
    logic [N-1:0] q;
    bit           sv;
    int           src;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [N-1:0]      ring_q;
  logic signed [W:0] s_i, s_q, s_b, s_c;

  item_t sb[$];
  int n_run = 0, n_fail = 0;
  int idx = 0, src = 0;
  bit sv = 1'b0, done = 1'b0;
  int last_i = 0, last_q = 0, last_b = 0, last_c = 0;
  logic [N-1:0] frc_val;

  always #(CLK_P / 2) clk = ~clk;

  jss_synth #(.N(N), .W(W)) u_jss_synth (
    .clk (clk), .rst (rst), .en (en), .ring_q (ring_q),
    .sample_i (s_i), .sample_q (s_q), .sample_b (s_b), .sample_c (s_c)
  );

  function automatic logic [N-1:0] jstate(int s);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = ((s - k - 1 + 2 * N) % (2 * N)) < N;
    return v;
  endfunction

  function automatic int refv(int s, int lag);
    return int'(-$cos(real'(s - lag) * PI / real'(N)) * real'(FULL));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(int a, int e);
    return (a - e <= 1) && (e - a <= 1);
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(bit e);
    item_t it;
    @(negedge clk);
    en = e;
    if (e) begin src = idx; sv = 1'b1; idx = (idx + 1) % (2 * N); end
    it.kind = e ? 0 : 2; it.q = jstate(idx); it.sv = sv; it.src = src;
    sb.push_back(it);
  endtask

  task automatic reset_cycle();
    item_t it;
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    idx = 0; sv = 1'b0;
    it.kind = 1; it.q = '0; it.sv = 1'b0; it.src = 0;
    sb.push_back(it);
  endtask

  task automatic inject(logic [N-1:0] p);
    item_t it;
    reset_cycle();
    @(negedge clk);
    frc_val = p;
    force u_jss_synth.u_ring.q_r = frc_val;
    #1;
    release u_jss_synth.u_ring.q_r;
    rst = 1'b0; en = 1'b1;
    idx = 0; sv = 1'b0;
    it.kind = 3; it.q = '0; it.sv = 1'b0; it.src = 0;
    sb.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle and compares after the edge.
  always @(posedge clk) begin
    item_t it;
    #3;
    if (sb.size() != 0) begin
      it = sb.pop_front();
      case (it.kind)
        1: begin
          check(ring_q == '0, "R1 ring", int'(ring_q), 0);
          check(s_i == 0 && s_q == 0 && s_b == 0 && s_c == 0,
                "R1 samples", int'(s_i), 0);
        end
        2: begin
          check(ring_q == it.q, "R9 ring", int'(ring_q), int'(it.q));
          check(int'(s_i) == last_i && int'(s_q) == last_q &&
                int'(s_b) == last_b && int'(s_c) == last_c,
                "R9 samples", int'(s_i), last_i);
        end
        3: check(ring_q == '0, "R8 recovery", int'(ring_q), 0);
        default: begin
          check(ring_q == it.q, "R2 R3 ring", int'(ring_q), int'(it.q));
          if (it.sv) begin
            check(near(int'(s_i), refv(it.src, 0)), "R5 R10 main",
                  int'(s_i), refv(it.src, 0));
            check(near(int'(s_q), refv(it.src, N / 2)), "R6 quad",
                  int'(s_q), refv(it.src, N / 2));
            check(near(int'(s_b), refv(it.src, 2 * N / 3)), "R7 phase b",
                  int'(s_b), refv(it.src, 2 * N / 3));
            check(near(int'(s_c), refv(it.src, 4 * N / 3)), "R7 phase c",
                  int'(s_c), refv(it.src, 4 * N / 3));
            if (it.src == 0)
              check(int'(s_i) == -FULL, "R4 all zeros", int'(s_i), -FULL);
            if (it.src == N)
              check(int'(s_i) == FULL, "R4 all ones", int'(s_i), FULL);
          end
        end
      endcase
      last_i = int'(s_i); last_q = int'(s_q);
      last_b = int'(s_b); last_c = int'(s_c);
    end
  end

  initial begin
    logic [N-1:0] bad [5];
    bad[0] = 6'b010000; bad[1] = 6'b101010; bad[2] = 6'b000101;
    bad[3] = 6'b110110; bad[4] = 6'b011100;
    for (int i = 0; i < 3; i++) reset_cycle();
    @(negedge clk); rst = 1'b0;
    begin item_t it; it.kind = 2; it.q = '0; it.sv = 1'b0; it.src = 0;
      sb.push_back(it); end
    for (int i = 0; i < 2 * N * 2 + 3; i++) step(1'b1);
    for (int i = 0; i < 30; i++) step((i % 3) != 1);
    for (int i = 0; i < 12; i++) step((i % 5) == 0);
    for (int j = 0; j < 5; j++) begin
      inject(bad[j]);
      for (int i = 0; i < 2 * N + 2; i++) step(1'b1);
      step(1'b0);
    end
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule